// File: doc/BRIEF.md
# Serial Bus Controller Interrupt Register Set

This block holds the interrupt state of a serial bus controller. Ten event pulse inputs (one position unused) feed a sticky status register. Software reads the status register and clears bits by writing ones back to them. Interrupt enables are never written directly. One write-only port sets enable bits and a second write-only port clears them, and a read-only mask view shows which enables are currently active.

A level interrupt output is high whenever any status bit is both pending and enabled. A second level output does the same for the error events only. The register bus is a plain single-cycle interface. A write takes effect at the clock edge where the write strobe is high. Read data is a combinational function of the address and the registers.

Top module: `sbc_irq_regs`

## Requirements
- R1: After reset, every status bit and every enable bit is 0, the status and mask views read 0, and both interrupt outputs are low.
- R2: A high pulse on an event input sets its status bit (offset 0x10) at the next clock edge, whether or not that event is enabled. The bit positions are: complete=0, data threshold=1, NACK=2, timeout=3, slave ready=4, receive overflow=5, transmit overflow=6, receive underflow=7, arbitration lost=9. Position 8 is unused: its status and enable bits always read 0.
- R3: Writing to offset 0x10 clears each status bit written as 1 and leaves bits written as 0 alone. Writing back a value just read from the status register therefore clears exactly those bits.
- R4: Writing to the enable port (offset 0x24) sets each enable bit written as 1. A 0 has no effect.
- R5: Writing to the disable port (offset 0x28) clears each enable bit written as 1. A 0 has no effect.
- R6: Offset 0x20 reads the current enables, with 1 meaning enabled. The enable port, the disable port and unmapped offsets all read 0.
- R7: `irq_out` is high exactly when some status bit and its enable bit are both 1, and it follows register changes in the same cycle.
- R8: If an event pulse and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R9: `err_irq` is high exactly when an enabled, pending bit belongs to the error group: arbitration lost, receive underflow, transmit overflow, receive overflow and NACK.
- R10: Status and enable bits keep their values through cycles with no event and no write to the register that controls them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| evt_pulse | input | 10 | One pulse input per event position |
| irq_out | output | 1 | Any enabled event pending |
| err_irq | output | 1 | Any enabled error-group event pending |

## Verification
A status bit stuck at 1 or at 0 shows in the status read-back and on `irq_out` in the cycle after the event or write that should have changed it. An enable bit in the wrong state shows just as quickly in the mask view and as a wrong interrupt level. The bench covers every bit position in turn so that a swapped or dropped position appears as a wrong single-bit pattern. It also forces the set-versus-clear collision and the write-zero cases, where a wrong priority or a missing qualifier shows on the very next read.

// File: rtl/sbc_irq_pkg.sv
`timescale 1ns/1ps
package sbc_irq_pkg;
   localparam int EV_W = 10;

   localparam int B_COMPLETE = 0;
   localparam int B_DATA     = 1;
   localparam int B_NACK     = 2;
   localparam int B_TIMEOUT  = 3;
   localparam int B_SLV_RDY  = 4;
   localparam int B_RX_OVF   = 5;
   localparam int B_TX_OVF   = 6;
   localparam int B_RX_UNF   = 7;
   localparam int B_ARB_LOST = 9;

   localparam logic [EV_W-1:0] VALID_MASK =
      EV_W'((1 << B_COMPLETE) | (1 << B_DATA) | (1 << B_NACK) |
            (1 << B_TIMEOUT) | (1 << B_SLV_RDY) | (1 << B_RX_OVF) |
            (1 << B_TX_OVF) | (1 << B_RX_UNF) | (1 << B_ARB_LOST));

   localparam logic [EV_W-1:0] ERR_MASK =
      EV_W'((1 << B_ARB_LOST) | (1 << B_RX_UNF) | (1 << B_TX_OVF) |
            (1 << B_RX_OVF) | (1 << B_NACK));

   localparam int OFF_STATUS  = 'h10;
   localparam int OFF_MASK    = 'h20;
   localparam int OFF_ENABLE  = 'h24;
   localparam int OFF_DISABLE = 'h28;
   localparam int MIN_ADDR_W  = 6;
endpackage

// File: rtl/sbc_irq_status.sv
`timescale 1ns/1ps
module sbc_irq_status #(
   parameter int                W     = 10,
   parameter logic [W-1:0]      VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] stat_q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (VALID[i]) begin : g_live
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_vec[i]) bit_q <= 1'b1;
            else if (clr_vec[i]) bit_q <= 1'b0;
         end
         assign stat_q[i] = bit_q;
      end else begin : g_hole
         assign stat_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sbc_irq_enable.sv
`timescale 1ns/1ps
module sbc_irq_enable #(
   parameter int           W     = 10,
   parameter logic [W-1:0] VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] on_vec,
   input  logic [W-1:0] off_vec,
   output logic [W-1:0] en_q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (VALID[i]) begin : g_live
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (off_vec[i]) bit_q <= 1'b0;
            else if (on_vec[i])  bit_q <= 1'b1;
         end
         assign en_q[i] = bit_q;
      end else begin : g_hole
         assign en_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sbc_irq_rdmux.sv
`timescale 1ns/1ps
module sbc_irq_rdmux #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int W        = 10,
   parameter int OFF_STAT = 'h10,
   parameter int OFF_MSK  = 'h20
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      stat_q,
   input  logic [W-1:0]      en_q,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFF_MSK);

   always_comb begin
      rdata = '0;
      if (addr == A_STAT)     rdata[W-1:0] = stat_q;
      else if (addr == A_MSK) rdata[W-1:0] = en_q;
   end
endmodule

// File: rtl/sbc_irq_regs.sv
`timescale 1ns/1ps
module sbc_irq_regs
   import sbc_irq_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [EV_W-1:0]   evt_pulse,
   output logic              irq_out,
   output logic              err_irq
);
   localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
   localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFF_ENABLE);
   localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(OFF_DISABLE);

   if (ADDR_W < MIN_ADDR_W) begin : g_chk_addr
      $error("sbc_irq_regs: ADDR_W too small for the register offsets");
   end
   if (DATA_W < EV_W) begin : g_chk_data
      $error("sbc_irq_regs: DATA_W narrower than the event vector");
   end

   logic [EV_W-1:0] wr_bits;
   logic [EV_W-1:0] clr_vec, on_vec, off_vec;
   logic [EV_W-1:0] stat_q, en_q;
   logic [EV_W-1:0] live;

   assign wr_bits = bus_wdata[EV_W-1:0];
   assign clr_vec = (bus_wr && bus_addr == A_STATUS)  ? wr_bits : '0;
   assign on_vec  = (bus_wr && bus_addr == A_ENABLE)  ? wr_bits : '0;
   assign off_vec = (bus_wr && bus_addr == A_DISABLE) ? wr_bits : '0;

   sbc_irq_status #(.W(EV_W), .VALID(VALID_MASK)) u_status (
      .clk(clk), .rst_n(rst_n), .set_vec(evt_pulse), .clr_vec(clr_vec), .stat_q(stat_q)
   );

   sbc_irq_enable #(.W(EV_W), .VALID(VALID_MASK)) u_enable (
      .clk(clk), .rst_n(rst_n), .on_vec(on_vec), .off_vec(off_vec), .en_q(en_q)
   );

   sbc_irq_rdmux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(EV_W),
      .OFF_STAT(OFF_STATUS), .OFF_MSK(OFF_MASK)
   ) u_rdmux (
      .addr(bus_addr), .stat_q(stat_q), .en_q(en_q), .rdata(bus_rdata)
   );

   assign live    = stat_q & en_q;
   assign irq_out = |live;
   assign err_irq = |(live & ERR_MASK);
endmodule

// File: rtl/sbc_irq_regs_chk.sv
`timescale 1ns/1ps
module sbc_irq_regs_chk
   import sbc_irq_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [EV_W-1:0]   evt_pulse,
   input logic              irq_out,
   input logic [EV_W-1:0]   stat_q,
   input logic [EV_W-1:0]   en_q
);
   localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
   localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFF_ENABLE);
   localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(OFF_DISABLE);

   assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_pulse & VALID_MASK)) |=>
      ((stat_q & $past(evt_pulse & VALID_MASK)) == $past(evt_pulse & VALID_MASK)));

   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_STATUS && ((evt_pulse & bus_wdata[EV_W-1:0]) == '0)) |=>
      ((stat_q & $past(bus_wdata[EV_W-1:0])) == '0));

   assert_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_ENABLE) |=>
      ((en_q & $past(bus_wdata[EV_W-1:0] & VALID_MASK)) == $past(bus_wdata[EV_W-1:0] & VALID_MASK)));

   assert_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DISABLE) |=>
      ((en_q & $past(bus_wdata[EV_W-1:0])) == '0));

   assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q == '0) |-> !irq_out);

   assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(en_q));
endmodule

bind sbc_irq_regs sbc_irq_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .evt_pulse(evt_pulse), .irq_out(irq_out),
   .stat_q(stat_q), .en_q(en_q)
);

// File: tb/sbc_irq_regs_bench.sv
`timescale 1ns/1ps
module sbc_irq_regs_bench;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam logic [9:0] VM   = 10'h2FF;
   localparam logic [9:0] ERRM = 10'h2E4;
   localparam logic [AW-1:0] A_ST = 8'h10, A_MK = 8'h20, A_EN = 8'h24, A_DI = 8'h28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [9:0] evt_pulse = '0;
   logic irq_out, err_irq;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sbc_irq_regs #(.ADDR_W(AW), .DATA_W(DW)) u_sbc_irq_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
      .irq_out(irq_out), .err_irq(err_irq)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic pulse(input logic [9:0] v);
      evt_pulse = v;
      tick();
      evt_pulse = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      logic [DW-1:0] snap;
      logic [9:0] one;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_ST, v); chk("R1 status", v, 0);
      rd(A_MK, v); chk("R1 mask", v, 0);
      chk("R1 irq", {31'b0, irq_out}, 0);
      chk("R1 err", {31'b0, err_irq}, 0);

      // per-position sweep
      for (int i = 0; i < 10; i++) begin
         one = 10'(1 << i);
         pulse(one);
         rd(A_ST, v); chk($sformatf("R2 pos %0d", i), v, DW'(one & VM));
         chk($sformatf("R7 masked pos %0d", i), {31'b0, irq_out}, 0);
         wr(A_EN, DW'(one));
         rd(A_MK, v); chk($sformatf("R4/R6 pos %0d", i), v, DW'(one & VM));
         chk($sformatf("R7 pos %0d", i), {31'b0, irq_out}, {31'b0, |(one & VM)});
         chk($sformatf("R9 pos %0d", i), {31'b0, err_irq}, {31'b0, |(one & ERRM)});
         rd(A_EN, v); chk("R6 enable port reads 0", v, 0);
         rd(A_DI, v); chk("R6 disable port reads 0", v, 0);
         wr(A_DI, DW'(one));
         rd(A_MK, v); chk($sformatf("R5 pos %0d", i), v, 0);
         chk($sformatf("R7 off pos %0d", i), {31'b0, irq_out}, 0);
         rd(A_ST, v); chk($sformatf("R10 pos %0d", i), v, DW'(one & VM));
         wr(A_ST, DW'(one));
         rd(A_ST, v); chk($sformatf("R3 pos %0d", i), v, 0);
      end

      // write-zero cases
      wr(A_EN, 32'h3FF);
      rd(A_MK, v); chk("R4 all", v, 32'h2FF);
      wr(A_EN, 32'h0);
      rd(A_MK, v); chk("R4 zero no effect", v, 32'h2FF);
      wr(A_DI, 32'h0);
      rd(A_MK, v); chk("R5 zero no effect", v, 32'h2FF);
      wr(A_DI, 32'h00F);
      rd(A_MK, v); chk("R5 partial", v, 32'h2F0);
      pulse(10'h3FF);
      rd(A_ST, v); chk("R2 all", v, 32'h2FF);
      wr(A_ST, 32'h0);
      rd(A_ST, v); chk("R3 zero no effect", v, 32'h2FF);
      wr(A_ST, 32'h0F0);
      rd(A_ST, v); chk("R3 partial", v, 32'h20F);
      chk("R7 arb lost", {31'b0, irq_out}, 1);
      chk("R9 arb lost", {31'b0, err_irq}, 1);
      wr(A_ST, 32'h200);
      chk("R7 low bits disabled", {31'b0, irq_out}, 0);
      chk("R9 cleared", {31'b0, err_irq}, 0);
      pulse(10'h010);
      chk("R9 non-error", {31'b0, err_irq}, 0);
      chk("R7 non-error", {31'b0, irq_out}, 1);
      rd(A_ST, snap);
      wr(A_ST, snap);
      rd(A_ST, v); chk("R3 write back", v, 0);

      // collision: bit 1 set and cleared together, bit 3 cleared alone
      pulse(10'h008);
      bus_addr = A_ST; bus_wdata = 32'h00A; bus_wr = 1'b1; evt_pulse = 10'h002;
      tick();
      bus_wr = 1'b0; evt_pulse = '0;
      rd(A_ST, v); chk("R8 set wins", v, 32'h002);
      rd(8'h04, v); chk("R6 unmapped", v, 0);
      repeat (3) tick();
      rd(A_ST, v); chk("R10 held", v, 32'h002);

      // R1 reset mid-run
      rst_n = 1'b0; tick(); rst_n = 1'b1;
      rd(A_ST, v); chk("R1 status after reset", v, 0);
      rd(A_MK, v); chk("R1 mask after reset", v, 0);
      chk("R1 irq after reset", {31'b0, irq_out}, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule